// File: doc/BRIEF.md
# Test access port with bypass-fallback instruction decoding

This block is a serial test access port for a device that carries no boundary-scan chain. It has the sixteen-state test controller clocked by TCK, a six-bit instruction register and a decoder. The decoder picks which shift path sits between TDI and TDO: a one-bit bypass stage, a 32-bit identification register, or one of three configuration shift registers. Both standard boundary-scan instructions, the external-test code and the sample code, take the bypass path. Any code whose top bit is set does the same.

A group of command codes selects no shift path of its own. The bypass stage carries their scans. Each command code raises one strobe line for exactly one TCK cycle when the controller first reaches Run-Test/Idle straight from Update-IR. Program, erase, latch, power and calibration logic elsewhere on the chip acts on those strobes. The three configuration shift registers keep their contents between scans, so whatever was shifted in can be shifted out again.

Top module: `tap_bypass_port`

## Requirements
- R1: The instruction register is 6 bits wide and shifts least significant bit first. On every Capture-IR it loads 000001, so the first six bits out of an IR scan are 1,0,0,0,0,0.
- R2: Two events select the identification code 000101: a low trst_n, or five TCK cycles with TMS high followed by one with TMS low. After either, tdo_en and cmd_pulse are zero, and the next DR scan returns the identification value.
- R3: Code 000101 puts a 32-bit register in the DR path. It captures ID_VALUE on Capture-DR and shifts it out least significant bit first.
- R4: Any code with bit 5 set, 111111 among them, puts the one-bit bypass stage in the DR path. That stage captures 0 and delays TDI by one TCK.
- R5: The external-test code 000000 and the sample code 000100 put the bypass stage in the DR path.
- R6: Codes 000001, 000010 and 000011 select shift registers of 112, 40 and 16 bits. These registers are not loaded on Capture-DR, so each keeps the data shifted in until it is shifted again.
- R7: Codes 001000 + k, for k = 0 to 9, are commands in this order: latch, read, program, erase, bulk erase, security fuse, power down, power up, reload, calibrate. cmd_pulse[k] is high for exactly the first TCK cycle in Run-Test/Idle entered from Update-IR. During a command code the DR path is the bypass stage.
- R8: No strobe fires for codes that are not commands, and none fires on entering Run-Test/Idle from Update-DR. Unassigned codes with bit 5 clear also use the bypass stage.
- R9: TDI is taken on the rising TCK edge, and TDO changes only on the falling edge. tdo_en is high only in Shift-DR and Shift-IR, and tdo is 0 whenever tdo_en is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_en | output | 1 | High while a shift state drives tdo |
| cmd_pulse | output | 10 | One-cycle command strobes, bit k for command k |

## Verification
If the controller is in the wrong state, the error shows within one TCK. tdo_en rises or falls a cycle early or late, and the captured instruction pattern reaches TDO at the wrong bit position. A decode error shows in the next DR scan: the measured shift-path length changes, by the difference between one bit and the 16, 40, 112 or 32 bits of the other paths. If the command strobe is armed in the wrong state, it fires in the wrong cycle or fires after a DR update. The bench samples cmd_pulse in the first two Run-Test/Idle cycles after every scan, so it catches that case.

// File: rtl/tap_pkg.sv
package tap_pkg;
    parameter int IR_W = 6;
    parameter int NCMD = 10;
    parameter logic [IR_W-1:0] OP_EXTEST = 6'b000000;
    parameter logic [IR_W-1:0] OP_CFG    = 6'b000001;
    parameter logic [IR_W-1:0] OP_QCK    = 6'b000010;
    parameter logic [IR_W-1:0] OP_SIG    = 6'b000011;
    parameter logic [IR_W-1:0] OP_SAMPLE = 6'b000100;
    parameter logic [IR_W-1:0] OP_IDCODE = 6'b000101;
    parameter logic [IR_W-1:0] CMD_BASE  = 6'b001000;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI, ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR,
        ST_EX2_DR, ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR,
        ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_t;

    typedef enum logic [2:0] {
        SEL_BYP, SEL_ID, SEL_CFG, SEL_QCK, SEL_SIG
    } dr_sel_t;

    function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
        case (s)
            ST_TLR:    return m ? ST_TLR    : ST_RTI;
            ST_RTI:    return m ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: return m ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: return m ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: return m ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: return m ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: return m ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: return m ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: return m ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: return m ? ST_UPD_IR : ST_SHF_IR;
            default:   return m ? ST_SEL_DR : ST_RTI;
        endcase
    endfunction
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state_q
);
    tap_state_t state_d;

    always_comb begin
        state_d = tap_next(state_q, tms);
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= ST_TLR;
        else         state_q <= state_d;
    end

    // R2
    tlr_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_TLR && tms) |=> (state_q == ST_TLR));
endmodule

// File: rtl/tap_decode.sv
module tap_decode
    import tap_pkg::*;
(
    input  logic [IR_W-1:0] ir,
    output dr_sel_t         sel,
    output logic [NCMD-1:0] cmd_hot
);
    always_comb begin
        if (ir[IR_W-1])            sel = SEL_BYP;
        else if (ir == OP_IDCODE)  sel = SEL_ID;
        else if (ir == OP_CFG)     sel = SEL_CFG;
        else if (ir == OP_QCK)     sel = SEL_QCK;
        else if (ir == OP_SIG)     sel = SEL_SIG;
        else                       sel = SEL_BYP;
    end

    for (genvar k = 0; k < NCMD; k++) begin : g_cmd
        assign cmd_hot[k] = (ir == CMD_BASE + IR_W'(k));
    end

    always_comb begin
        // R4
        lead_one_bypass_chk: assert (!ir[IR_W-1] || sel == SEL_BYP);
    end
endmodule

// File: rtl/tap_bypass_port.sv
module tap_bypass_port
    import tap_pkg::*;
#(
    parameter logic [31:0] ID_VALUE = 32'h0A5C_3043,
    parameter int          CFG_W    = 112,
    parameter int          QCK_W    = 40,
    parameter int          SIG_W    = 16
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tms,
    input  logic            tdi,
    output logic            tdo,
    output logic            tdo_en,
    output logic [NCMD-1:0] cmd_pulse
);
    localparam int ID_W = 32;

    typedef struct packed {
        logic [IR_W-1:0]  ir_sr;
        logic [IR_W-1:0]  ir;
        logic             byp;
        logic [ID_W-1:0]  id;
        logic [CFG_W-1:0] cfg;
        logic [QCK_W-1:0] qck;
        logic [SIG_W-1:0] sig;
        logic             arm;
    } regs_t;

    regs_t           d, q;
    tap_state_t      state_q;
    dr_sel_t         sel;
    logic [NCMD-1:0] cmd_hot;
    logic            dr_bit;
    logic            tdo_q, tdo_en_q;

    tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state_q(state_q));
    tap_decode u_dec (.ir(q.ir), .sel(sel), .cmd_hot(cmd_hot));

    always_comb begin
        d     = q;
        d.arm = (state_q == ST_UPD_IR);
        case (state_q)
            ST_TLR:    d.ir    = OP_IDCODE;
            ST_CAP_IR: d.ir_sr = {{(IR_W-2){1'b0}}, 2'b01};
            ST_SHF_IR: d.ir_sr = {tdi, q.ir_sr[IR_W-1:1]};
            ST_UPD_IR: d.ir    = q.ir_sr;
            ST_CAP_DR: begin
                d.byp = 1'b0;
                if (sel == SEL_ID) d.id = ID_VALUE;
            end
            ST_SHF_DR: begin
                case (sel)
                    SEL_ID:  d.id  = {tdi, q.id[ID_W-1:1]};
                    SEL_CFG: d.cfg = {tdi, q.cfg[CFG_W-1:1]};
                    SEL_QCK: d.qck = {tdi, q.qck[QCK_W-1:1]};
                    SEL_SIG: d.sig = {tdi, q.sig[SIG_W-1:1]};
                    default: d.byp = tdi;
                endcase
            end
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            q    <= '0;
            q.ir <= OP_IDCODE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (sel)
            SEL_ID:  dr_bit = q.id[0];
            SEL_CFG: dr_bit = q.cfg[0];
            SEL_QCK: dr_bit = q.qck[0];
            SEL_SIG: dr_bit = q.sig[0];
            default: dr_bit = q.byp;
        endcase
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo_q    <= 1'b0;
            tdo_en_q <= 1'b0;
        end else begin
            tdo_en_q <= (state_q == ST_SHF_IR) || (state_q == ST_SHF_DR);
            if (state_q == ST_SHF_IR)      tdo_q <= q.ir_sr[0];
            else if (state_q == ST_SHF_DR) tdo_q <= dr_bit;
            else                           tdo_q <= 1'b0;
        end
    end

    assign tdo       = tdo_q;
    assign tdo_en    = tdo_en_q;
    assign cmd_pulse = (state_q == ST_RTI && q.arm) ? cmd_hot : '0;

    // R1
    capir_pattern_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_CAP_IR) |=> (q.ir_sr[1:0] == 2'b01));
    // R6
    cfg_keep_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_CAP_DR) |=> (q.cfg == $past(q.cfg)));
    // R7
    pulse_single_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (cmd_pulse != '0) |=> (cmd_pulse == '0));
    // R9
    tdo_en_state_chk: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (state_q == ST_SHF_DR || state_q == ST_SHF_IR));
endmodule

// File: tb/sim_tap_bypass_port.sv
module sim_tap_bypass_port;
    localparam logic [31:0]  ID   = 32'h0A5C_3043;
    localparam logic [127:0] PAT  = 128'hC3A5_96F0_1E2D_3C4B_5A69_7887_F00F_1234;
    localparam int NV = 20;
    // {opcode[23:18], path length[17:10], expected strobe[9:0]}
    localparam logic [23:0] VEC [NV] = '{
        {6'b000000, 8'd1,   10'h000}, {6'b000100, 8'd1,   10'h000},
        {6'b111111, 8'd1,   10'h000}, {6'b100101, 8'd1,   10'h000},
        {6'b000101, 8'd32,  10'h000}, {6'b000001, 8'd112, 10'h000},
        {6'b000010, 8'd40,  10'h000}, {6'b000011, 8'd16,  10'h000},
        {6'b001000, 8'd1,   10'h001}, {6'b001001, 8'd1,   10'h002},
        {6'b001010, 8'd1,   10'h004}, {6'b001011, 8'd1,   10'h008},
        {6'b001100, 8'd1,   10'h010}, {6'b001101, 8'd1,   10'h020},
        {6'b001110, 8'd1,   10'h040}, {6'b001111, 8'd1,   10'h080},
        {6'b010000, 8'd1,   10'h100}, {6'b010001, 8'd1,   10'h200},
        {6'b010010, 8'd1,   10'h000}, {6'b011111, 8'd1,   10'h000}
    };

    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic tdo, tdo_en;
    logic [9:0] cmd_pulse;
    int nchk = 0, nfail = 0;
    logic edge_bad = 1'b0;

    always #5 tck = ~tck;

    tap_bypass_port u0 (.tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
                        .tdo(tdo), .tdo_en(tdo_en), .cmd_pulse(cmd_pulse));

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic tick(input logic m, input logic di);
        logic pre;
        tms = m; tdi = di; pre = tdo;
        @(posedge tck); #1;
        if (tdo !== pre) edge_bad = 1'b1;
        @(negedge tck); #1;
    endtask

    task automatic scan_ir(input logic [5:0] op, output logic [5:0] cap,
                           output logic [9:0] p0, output logic en_sh);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        en_sh = tdo_en;
        for (int i = 0; i < 6; i++) begin
            cap[i] = tdo;
            tick(i == 5, op[i]);
        end
        tick(1, 0); tick(0, 0);
        p0 = cmd_pulse;
    endtask

    task automatic scan_dr(input int n, input logic [127:0] din,
                           output logic [127:0] dout, output logic [9:0] p0);
        dout = '0;
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            tick(i == n - 1, din[i]);
        end
        tick(1, 0); tick(0, 0);
        p0 = cmd_pulse;
    endtask

    initial begin
        #2_000_000;
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [5:0]   cap;
        logic [9:0]   p0;
        logic [127:0] dout;
        logic         en_sh;
        string        rq;
        int           len;

        repeat (3) @(negedge tck);
        #1;
        chk("R2 reset tdo_en", 128'(tdo_en), 128'd0);
        chk("R2 reset cmd_pulse", 128'(cmd_pulse), 128'd0);
        chk("R9 reset tdo", 128'(tdo), 128'd0);
        trst_n = 1'b1;
        tick(0, 0);
        chk("R9 idle tdo_en", 128'(tdo_en), 128'd0);
        scan_dr(32, 128'd0, dout, p0);
        chk("R2 idcode after trst", dout[31:0], 128'(ID));

        for (int v = 0; v < NV; v++) begin
            len = int'(VEC[v][17:10]);
            if (VEC[v][23])                                   rq = "R4";
            else if (VEC[v][23:18] == 6'b0 || VEC[v][23:18] == 6'b000100) rq = "R5";
            else if (VEC[v][9:0] != 10'h0)                    rq = "R7";
            else if (len == 32)                               rq = "R3";
            else if (len > 1)                                 rq = "R6";
            else                                              rq = "R8";
            edge_bad = 1'b0;
            scan_ir(VEC[v][23:18], cap, p0, en_sh);
            chk("R1 capture pattern", 128'(cap), 128'd1);
            chk("R9 tdo_en in Shift-IR", 128'(en_sh), 128'd1);
            chk({rq, " strobe"}, 128'(p0), 128'(VEC[v][9:0]));
            tick(0, 0);
            chk("R7 strobe one cycle", 128'(cmd_pulse), 128'd0);
            scan_dr(128, PAT, dout, p0);
            chk({rq, " path length"}, dout >> len, (PAT << len) >> len);
            if (len == 1)  chk("R4 bypass capture", 128'(dout[0]), 128'd0);
            if (len == 32) chk("R3 id capture", dout[31:0], 128'(ID));
            chk("R8 no strobe after Update-DR", 128'(p0), 128'd0);
            chk("R9 tdo stable on rising edge", 128'(edge_bad), 128'd0);
        end

        scan_ir(6'b000010, cap, p0, en_sh);
        scan_dr(40, 128'h00_9A3C_5E71_D4, dout, p0);
        scan_dr(40, 128'd0, dout, p0);
        chk("R6 quick register retains", dout, 128'h00_9A3C_5E71_D4);
        scan_ir(6'b000011, cap, p0, en_sh);
        scan_dr(16, 128'h0000_B6C1, dout, p0);
        scan_dr(16, 128'd0, dout, p0);
        chk("R6 signature register retains", dout, 128'h0000_B6C1);

        scan_ir(6'b000001, cap, p0, en_sh);
        for (int i = 0; i < 5; i++) tick(1, 0);
        tick(0, 0);
        chk("R2 tms reset cmd_pulse", 128'(cmd_pulse), 128'd0);
        scan_dr(32, 128'd0, dout, p0);
        chk("R2 idcode after tms reset", dout[31:0], 128'(ID));

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule